// File: doc/BRIEF.md
# Sticky-Inhibit Serial Pattern Recognizer

This block watches a serial bit stream and raises a flag whenever the three most recent accepted bits read 0, 1, 0 in arrival order. Matches may overlap, so the stream 0-1-0-1-0 produces two hits. The stream can also contain a forbidden pattern: 1, 0, 0 in arrival order. Once that pattern has appeared, the flag is held low permanently. Only a synchronous reset arms detection again.

The recognizer is a Moore machine with seven states in a 3-bit register. The flag is taken from a registered decode of the state, so it carries no combinational path from the input. Each bit arrives with a valid qualifier. The block never applies back-pressure, so it has no ready output. A bit is accepted on every rising edge where `in_valid_i` is high. On cycles where it is low, nothing advances. The flag reflects every bit accepted up to and including the bit taken at the most recent edge.

Top module: `seq_guard_detect`

## Requirements
- R1: While `rst_i` is high at a rising edge, the machine returns to its initial state with no history, and `match_o` is 0 after that edge.
- R2: After an edge that accepts a bit, `match_o` is 1 exactly when both of these hold. First, the last three accepted bits since reset were 0, 1, 0, oldest first. Second, the sequence 1, 0, 0 has never been accepted since reset.
- R3: Matches overlap. In the accepted stream 0,1,0,1,0 from reset, the flag is 1 after the third bit and again after the fifth bit.
- R4: Once 1, 0, 0 has been accepted, `match_o` stays 0 for every later input until reset.
- R5: The flag is registered. It changes only at a rising edge. Its value after an accepting edge already includes the bit taken at that edge.
- R6: A cycle with `in_valid_i` low is ignored. Neither the history nor `match_o` changes.
- R7: A reset after the forbidden pattern re-arms detection. A following 0,1,0 sets the flag again.
- R8: From reset, the accepted stream 00101010010 yields flags 00010101000. The stream 11011010010 yields 00000001000. Each flag is the value after its bit's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Qualifies `in_bit_i`; the bit is taken at an edge where this is high |
| in_bit_i | input | 1 | Serial data bit |
| match_o | output | 1 | Registered flag: last three bits were 0,1,0 and 1,0,0 never seen |

## Verification
The bench targets several corner cases, each tied to a specific design mistake:
- Overlapping hits. A design that clears its history after a hit misses the second flag in 0-1-0-1-0.
- The forbidden pattern straight after a hit, as in 0-1-0-0. A design that treats the trap as ordinary history would raise the flag again on a later 0-1-0.
- Idle cycles inside a pattern. A design that shifts on an invalid cycle would miss a hit or report a false one.
- The two reference streams and a reset after trapping. A lock that survives reset would keep the flag low.
- Long random streams with frequent resets, which reach every state from many histories.

// File: rtl/seq_guard_pkg.sv
package seq_guard_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,  // nothing accepted since reset
    ST_Z    = 3'd1,  // only zeros so far
    ST_ZO   = 3'd2,  // history ends ...01
    ST_HIT  = 3'd3,  // history ends ...010
    ST_O    = 3'd4,  // history ends ...1 with a 1 or start before
    ST_OZ   = 3'd5,  // history ends ...10 with a 1 or start before
    ST_LOCK = 3'd6   // 1,0,0 seen: permanent inhibit
  } gstate_t;
endpackage

// File: rtl/seq_guard_next.sv
module seq_guard_next
  import seq_guard_pkg::*;
(
  input  gstate_t cur_i,
  input  logic    take_i,
  input  logic    bit_i,
  output gstate_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (take_i) begin
      unique case (cur_i)
        ST_IDLE: nxt_o = bit_i ? ST_O  : ST_Z;
        ST_Z:    nxt_o = bit_i ? ST_ZO : ST_Z;
        ST_ZO:   nxt_o = bit_i ? ST_O  : ST_HIT;
        ST_HIT:  nxt_o = bit_i ? ST_ZO : ST_LOCK;
        ST_O:    nxt_o = bit_i ? ST_O  : ST_OZ;
        ST_OZ:   nxt_o = bit_i ? ST_ZO : ST_LOCK;
        ST_LOCK: nxt_o = ST_LOCK;
        default: nxt_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_guard_state.sv
module seq_guard_state
  import seq_guard_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  gstate_t d_i,
  output gstate_t q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= ST_IDLE;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/seq_guard_flag.sv
module seq_guard_flag
  import seq_guard_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  gstate_t nxt_i,
  output logic    flag_o
);
  logic hit_dec;

  always_comb hit_dec = (nxt_i == ST_HIT);

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_o <= 1'b0;
    else       flag_o <= hit_dec;
  end
endmodule

// File: rtl/seq_guard_detect.sv
module seq_guard_detect
  import seq_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic in_valid_i,
  input  logic in_bit_i,
  output logic match_o
);
  gstate_t state_q;
  gstate_t state_d;

  seq_guard_next u_next (
    .cur_i  (state_q),
    .take_i (in_valid_i),
    .bit_i  (in_bit_i),
    .nxt_o  (state_d)
  );

  seq_guard_state u_state (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (state_d),
    .q_o   (state_q)
  );

  seq_guard_flag u_flag (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .nxt_i  (state_d),
    .flag_o (match_o)
  );
endmodule

// File: rtl/seq_guard_detect_chk.sv
module seq_guard_detect_chk (
  input logic clk_i,
  input logic rst_i,
  input logic in_valid_i,
  input logic in_bit_i,
  input logic match_o
);
  // independent history model: last three bits, fill count, forbidden flag
  logic [2:0] hist_q;
  logic [1:0] fill_q;
  logic       bad_q;
  logic [2:0] hist_n;
  logic [1:0] fill_n;

  always_comb begin
    hist_n = {hist_q[1:0], in_bit_i};
    fill_n = (fill_q == 2'd3) ? 2'd3 : fill_q + 2'd1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q <= 3'b000;
      fill_q <= 2'd0;
      bad_q  <= 1'b0;
    end else if (in_valid_i) begin
      hist_q <= hist_n;
      fill_q <= fill_n;
      if (fill_n == 2'd3 && hist_n == 3'b100) bad_q <= 1'b1;
    end
  end

  // R2: flag agrees with the history model
  a_r2_flag_model: assert property (@(posedge clk_i) disable iff (rst_i)
    match_o == (!bad_q && fill_q == 2'd3 && hist_q == 3'b010));

  // R4: inhibit is sticky
  a_r4_locked_low: assert property (@(posedge clk_i) disable iff (rst_i)
    bad_q |-> !match_o);

  // R6: idle cycle leaves the flag unchanged
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> $stable(match_o));

  // R5: a rising flag follows an accepted 0
  a_r5_rise_on_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i && in_bit_i |=> !match_o);
endmodule

bind seq_guard_detect seq_guard_detect_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .in_valid_i (in_valid_i),
  .in_bit_i   (in_bit_i),
  .match_o    (match_o)
);

// File: tb/seq_guard_detect_bench.sv
`timescale 1ns/1ps
module seq_guard_detect_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic match_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sbq[$];

  // bench model
  logic [2:0] m_hist = 3'b000;
  int         m_fill = 0;
  logic       m_bad = 1'b0;
  logic       m_exp = 1'b0;

  always #5 clk = ~clk;

  seq_guard_detect u_seq_guard_detect (
    .clk_i      (clk),
    .rst_i      (rst),
    .in_valid_i (in_valid),
    .in_bit_i   (in_bit),
    .match_o    (match_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one comparison after each edge that has a pending item
  always @(posedge clk) begin : mon
    item_t it;
    #2;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      check(match_o, it.exp, it.tag);
    end
  end

  task automatic model_reset();
    m_hist = 3'b000; m_fill = 0; m_bad = 1'b0; m_exp = 1'b0;
  endtask

  // driver: applies one cycle of input and queues the expected flag
  task automatic send(input logic v, input logic b, input string tag,
                      input bit use_lit, input logic lit);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_bit = b;
    if (v) begin
      m_hist = {m_hist[1:0], b};
      if (m_fill < 3) m_fill++;
      if (m_fill == 3 && m_hist == 3'b100) m_bad = 1'b1;
      m_exp = !m_bad && m_fill == 3 && m_hist == 3'b010;
    end
    it.exp = use_lit ? lit : m_exp;
    if (!v) it.tag = "R6";
    else if (m_bad && !use_lit) it.tag = "R4";
    else it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(match_o, 1'b0, "R1");
  endtask

  task automatic send_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) send(1'b1, s[i] == "1", tag, 1'b0, 1'b0);
  endtask

  task automatic send_ref(input string si, input string so);
    for (int i = 0; i < si.len(); i++) send(1'b1, si[i] == "1", "R8", 1'b1, so[i] == "1");
  endtask

  task automatic finish_run();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #3_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    send_ref("00101010010", "00010101000");
    do_reset();
    send_ref("11011010010", "00000001000");
    do_reset();
    send_str("01010", "R3/R5");
    do_reset();
    // idle cycles inside a pattern
    send(1'b1, 1'b0, "R6", 1'b0, 1'b0);
    send(1'b0, 1'b1, "R6", 1'b0, 1'b0);
    send(1'b1, 1'b1, "R6", 1'b0, 1'b0);
    send(1'b0, 1'b0, "R6", 1'b0, 1'b0);
    send(1'b1, 1'b0, "R6", 1'b0, 1'b0);
    send(1'b0, 1'b1, "R6", 1'b0, 1'b0);
    // trap right after a hit, then try again
    send_str("0", "R4");
    send_str("010010", "R4");
    do_reset();
    send_str("010", "R7");
    // random streams with resets
    for (int n = 0; n < 12000; n++) begin
      if ($urandom_range(0, 39) == 0) do_reset();
      send($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, "R2", 1'b0, 1'b0);
    end
    finish_run();
  end
endmodule